// File: doc/BRIEF.md
# Serial-Loaded Control Register Bank

This block takes a three-wire serial programming stream (serial clock, serial data, latch strobe) and turns it into six 24-bit control words for a mixed-signal transmitter. Bits are shifted most significant first into a 24-bit shift register. On a rising edge of the latch strobe, the word is copied into the control register named by its three lowest bits.

All three serial wires are asynchronous to the system clock. They pass through a synchronizer chain, and edges are found in the system clock domain. The serial clock may run up to 20 MHz, provided each of its levels lasts at least `SYNC_STAGES + 1` system clock cycles.

Control word 5 is also decoded with two static configuration pins. The decode gives an RF output enable, a 2-bit local-oscillator port mode and a flag that routes an external LO to the modulator.

Top module: `serial_ctrl_bank`

## Requirements
- R1: On each rising edge of `sclk_i`, the value on `sdata_i` enters bit 0 of the 24-bit shift register and earlier bits move one place up. The first bit sent therefore ends up in bit 23 after 24 edges.
- R2: A transfer into a control register happens only on a rising edge of `sle_i`. Holding `sle_i` high while shifting more bits causes no further write. Without a rising edge, no control register changes.
- R3: When `sle_i` rises and the address field (shift register bits [2:0]) holds a value k from 0 to 5, the whole 24-bit word is stored in control register k. It appears on `regs_o[24*k +: 24]`, and the other registers keep their values.
- R4: When `sle_i` rises and the address field holds 6 or 7, no control register changes.
- R5: While `rst_n` is low, all control registers and the shift register are zero.
- R6: `rf_en_o` is 1 exactly when `out_en_i` is 1 and bit 6 of control register 5 is 1.
- R7: When `lo_sel_i` is 1, or bit 3 of register 5 (LO drive) is 1, the LO port is an output. `lo_mode_o` is then 2 (1x LO) if bit 5 of register 5 is 0, or 3 (2x LO) if that bit is 1.
- R8: When `lo_sel_i` is 0, bit 3 of register 5 is 0 and bit 4 of register 5 is 1, `lo_mode_o` is 0 (the port is an input for an external 2x LO).
- R9: When `lo_sel_i` is 0 and bits 3 and 4 of register 5 are both 0, `lo_mode_o` is 1 (the port is an output, but disabled).
- R10: `lo_ext_o` equals bit 4 of control register 5.
- R11: A control register holds its new word no later than `SYNC_STAGES + 1` system clock edges after the first edge that samples `sle_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first, asynchronous |
| sle_i | input | 1 | Latch strobe, asynchronous |
| out_en_i | input | 1 | RF output enable pin |
| lo_sel_i | input | 1 | LO port select pin |
| regs_o | output | 144 | Six control words; word k at bits [24*k +: 24] |
| rf_en_o | output | 1 | Decoded RF output enable |
| lo_mode_o | output | 2 | LO port mode: 0 input, 1 disabled output, 2 1x out, 3 2x out |
| lo_ext_o | output | 1 | Route the external LO to the modulator |

## Verification
A serial edge reaches the shift register three system clock edges after it is first sampled. The bench holds each serial clock level for four system clock cycles, which keeps bit capture clear of that latency.

After a latch rising edge, the register write lands by the third edge. The bench waits six cycles before it reads `regs_o`, and it samples on the falling system clock edge.

The decoded outputs (`rf_en_o`, `lo_mode_o`, `lo_ext_o`) follow register 5 and the two pins with no delay. They are checked one time unit after a pin change, or after the register 5 write has settled.

// File: rtl/serial_ctrl_bank.sv
module serial_ctrl_bank #(
  parameter int WORD_W      = 24,
  parameter int NUM_REGS    = 6,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DECODE_REG  = 5,
  parameter int BIT_DRIVE   = 3,
  parameter int BIT_EXTRT   = 4,
  parameter int BIT_DIV2    = 5,
  parameter int BIT_OUTEN   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk_i,
  input  logic                       sdata_i,
  input  logic                       sle_i,
  input  logic                       out_en_i,
  input  logic                       lo_sel_i,
  output logic [NUM_REGS*WORD_W-1:0] regs_o,
  output logic                       rf_en_o,
  output logic [1:0]                 lo_mode_o,
  output logic                       lo_ext_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_sy, data_sy, le_sy;
  logic                   sclk_q, le_q;
  logic [WORD_W-1:0]      shreg;
  logic [WORD_W-1:0]      regs_q [NUM_REGS];

  wire                sclk_rise = sclk_sy[TOP] & ~sclk_q;
  wire                le_rise   = le_sy[TOP] & ~le_q;
  wire [ADDR_W-1:0]   addr      = shreg[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      data_sy <= '0;
      le_sy   <= '0;
      sclk_q  <= 1'b0;
      le_q    <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      data_sy <= {data_sy[SYNC_STAGES-2:0], sdata_i};
      le_sy   <= {le_sy[SYNC_STAGES-2:0], sle_i};
      sclk_q  <= sclk_sy[TOP];
      le_q    <= le_sy[TOP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[WORD_W-2:0], data_sy[TOP]};
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               regs_q[k] <= '0;
      else if (le_rise && addr == ADDR_W'(k))   regs_q[k] <= shreg;
    end
    assign regs_o[k*WORD_W +: WORD_W] = regs_q[k];
  end

  wire [WORD_W-1:0] dreg = regs_q[DECODE_REG];
  wire lo_out = lo_sel_i | dreg[BIT_DRIVE];

  assign rf_en_o   = out_en_i & dreg[BIT_OUTEN];
  assign lo_ext_o  = dreg[BIT_EXTRT];
  assign lo_mode_o = lo_out            ? {1'b1, dreg[BIT_DIV2]} :
                     dreg[BIT_EXTRT]   ? 2'd0 : 2'd1;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shreg[0] == $past(data_sy[TOP])); // R1
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(regs_o)); // R2
  AST_BAD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && addr >= ADDR_W'(NUM_REGS)) |=> $stable(regs_o)); // R4
  AST_RF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_i |-> !rf_en_o); // R6
  AST_LO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    lo_sel_i |-> lo_mode_o[1]); // R7
  AST_LO_INPUT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_mode_o == 2'd0) |-> lo_ext_o); // R8

endmodule

// File: tb/test_serial_ctrl_bank.sv
module test_serial_ctrl_bank;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, sle = 0, oen = 0, lsel = 0;
  logic [143:0] regs;
  logic rf_en, lo_ext;
  logic [1:0] lo_mode;
  logic [23:0] exp_q [6];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  serial_ctrl_bank i_serial_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
    .out_en_i(oen), .lo_sel_i(lsel), .regs_o(regs), .rf_en_o(rf_en),
    .lo_mode_o(lo_mode), .lo_ext_o(lo_ext));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      sdata = w[i];
      wait_cyc(4);
      sclk = 1;
      wait_cyc(4);
      sclk = 0;
    end
    wait_cyc(4);
  endtask

  task automatic pulse_latch();
    sle = 1;
    wait_cyc(6);
    sle = 0;
    wait_cyc(4);
  endtask

  task automatic compare_all(input string req);
    for (int k = 0; k < 6; k++)
      check(regs[k*24 +: 24] === exp_q[k], req, 32'(regs[k*24 +: 24]), 32'(exp_q[k]));
  endtask

  task automatic write_reg(input logic [23:0] w);
    shift_word(w);
    pulse_latch();
    if (w[2:0] < 3'd6) exp_q[w[2:0]] = w;
  endtask

  task automatic test_reset();
    for (int k = 0; k < 6; k++) exp_q[k] = '0;
    compare_all("R5");
    check(rf_en === 0, "R5 rf", 32'(rf_en), 0);
  endtask

  task automatic test_write_all();
    for (int k = 0; k < 6; k++) write_reg({8'hA0 + 8'(k), 13'h1234 + 13'(k), 3'(k)});
    compare_all("R3 R1");
    write_reg(24'h800000 | 24'd2);
    check(regs[2*24 +: 24] === 24'h800002, "R1 msb first", 32'(regs[2*24 +: 24]), 32'h800002);
    compare_all("R3");
  endtask

  task automatic test_latency();
    shift_word(24'h5A5A51);
    sle = 1;
    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(regs[24 +: 24] === 24'h5A5A51, "R11", 32'(regs[24 +: 24]), 32'h5A5A51);
    exp_q[1] = 24'h5A5A51;
    wait_cyc(4);
    sle = 0;
    wait_cyc(4);
  endtask

  task automatic test_bad_addr();
    write_reg(24'hFFFFF6);
    compare_all("R4 addr6");
    write_reg(24'hFFFFF7);
    compare_all("R4 addr7");
  endtask

  task automatic test_latch_hold();
    shift_word(24'h111110);
    sle = 1;
    wait_cyc(6);
    exp_q[0] = 24'h111110;
    shift_word(24'h222220);
    compare_all("R2 held high");
    sle = 0;
    wait_cyc(6);
    compare_all("R2 no edge");
    pulse_latch();
    exp_q[0] = 24'h222220;
    compare_all("R2 new edge");
  endtask

  task automatic test_rf_en();
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 2; b++) begin
        write_reg({17'h0, 1'(b), 3'b000, 3'd5});
        oen = 1'(p);
        #1;
        check(rf_en === 1'(p & b), "R6", 32'(rf_en), 32'(p & b));
      end
    oen = 0;
  endtask

  task automatic test_lo_modes();
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 8; v++) begin
        logic drv, rt, dv;
        logic [1:0] e;
        drv = v[0]; rt = v[1]; dv = v[2];
        write_reg({18'h0, dv, rt, drv, 3'd5});
        lsel = 1'(s);
        #1;
        if (s == 1 || drv) e = {1'b1, dv};
        else if (rt) e = 2'd0;
        else e = 2'd1;
        check(lo_mode === e, (s == 1 || drv) ? "R7" : (rt ? "R8" : "R9"), 32'(lo_mode), 32'(e));
        check(lo_ext === rt, "R10", 32'(lo_ext), 32'(rt));
      end
    lsel = 0;
  endtask

  initial begin
    #200000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(5);
    test_reset();
    rst_n = 1;
    wait_cyc(3);
    test_write_all();
    test_latency();
    test_bad_addr();
    test_latch_hold();
    test_rf_en();
    test_lo_modes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule